// File: doc/BRIEF.md
# Port-to-Real Address Reconstructor

This block turns a 40-bit address seen on one memory channel back into the system real address it came from. A channel that belongs to an interleave group only receives part of the real address: the group-select bits were dropped when the address was spread across channels. The block puts them back. The way it does this depends on how many channels share the group.

For power-of-two group sizes, the block inserts low group-ID bits at bit 7 and moves the rest of the address up. Groups of three and six channels spread addresses with a rotation-based mod-3 hash instead. For those, the block runs the hash backwards, from the address bits it already has and the group ID, to recover the two missing top bits of the port address. It then places them above a boundary set by the group-size mask. The result is registered: it appears one clock after the input strobe, with an error flag for configurations the block cannot resolve.

Top module: `port_real_addr`

## Requirements
- R1: In every mode, bits [6:0] of the real address equal bits [6:0] of the port address.
- R2: With a channel count of 1 (chan_cnt_i = 4'd1), the real address is the port address zero-extended to 64 bits, and err_o stays low.
- R3: With channel counts 2, 4 and 8, the block inserts grp_id_i[0], grp_id_i[1:0] or grp_id_i[2:0] at bit 7. Port bits [39:7] move up by 1, 2 or 3 places. Real-address bits [63:43] are always zero.
- R4: With a channel count of 3, no bits are inserted. The intermediate address equals the port address, and two solved bits k are ORed in as described in R6 and R7.
- R5: With a channel count of 6, grp_id_i[0] is inserted at bit 7 and port bits [39:7] move up by one. The hash solve then uses grp_id_i & 3'b110 and only bit 8 of the intermediate address (bit 7 is treated as zero).
- R6: Let a one-hot residue code map a value v to 3'b100 >> (v mod 3). Rotating right adds 1 to the residue and rotating left subtracts 1. r2 starts from the code of intermediate bits [16:15]. It is rotated right by bits [18:17], then right again by bits [20:19]. r3 is the code of the group ID, rotated left by intermediate bits [8:7]. k (0 to 2) is the number of single left rotations of r3 that give r2.
- R7: k is shifted left by 30 plus the number of ones in grp_mask_i, then ORed into the intermediate address.
- R8: A channel count outside {1,2,3,4,6,8} passes the port address through zero-extended and raises err_o.
- R9: out_valid_o equals in_valid_i delayed by one clock. When in_valid_i is low, real_addr_o holds its previous value on the next clock.
- R10: After reset all outputs are zero. err_o is only high together with out_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input strobe |
| port_addr_i | input | 40 | Per-channel port address |
| chan_cnt_i | input | 4 | Channels per group, as a plain number |
| grp_id_i | input | 3 | Group ID of this channel |
| grp_mask_i | input | 11 | Group-size mask; its popcount sets the solved-bit position |
| out_valid_o | output | 1 | Result strobe, one clock after in_valid_i |
| real_addr_o | output | 64 | Reconstructed real address |
| err_o | output | 1 | Unsupported channel count or unsolvable hash |

## Verification
The assertions check the timing and shape properties on every cycle:
- the one-clock strobe delay and the hold of the address when no input arrives;
- preservation of the low seven bits;
- pass-through for a single channel;
- the error flag for unsupported counts;
- the always-zero upper bits;
- that at most one rotation candidate matches in the solver.

Only the bench scenarios can show that the solved value k is correct. They compare it against a residue-arithmetic model across both hash modes, odd and even group IDs, and empty and full group-size masks. The same scenarios confirm exact bit placement for the 2-, 4- and 8-channel inserts.

// File: rtl/port_real_addr_pkg.sv
`timescale 1ns/1ps
package port_real_addr_pkg;

  // Field positions the hash depends on (intermediate address bits)
  localparam int HB_SEL_LO = 7;
  localparam int HB_A0_LO  = 15;
  localparam int HB_A1_LO  = 17;
  localparam int HB_A2_LO  = 19;

  typedef logic [2:0] res3_t;

  function automatic res3_t b3_code(input logic [2:0] v);
    return res3_t'(3'b100 >> (v % 3'd3));
  endfunction

  function automatic res3_t rot_r1(input res3_t x);
    return {x[0], x[2:1]};
  endfunction

  function automatic res3_t rot_l1(input res3_t x);
    return {x[1:0], x[2]};
  endfunction

  function automatic res3_t rot_r(input res3_t x, input logic [1:0] n);
    res3_t y = x;
    for (int i = 0; i < 3; i++) if (2'(i) < n) y = rot_r1(y);
    return y;
  endfunction

  function automatic res3_t rot_l(input res3_t x, input logic [1:0] n);
    res3_t y = x;
    for (int i = 0; i < 3; i++) if (2'(i) < n) y = rot_l1(y);
    return y;
  endfunction

endpackage

// File: rtl/par_mode_dec.sv
`timescale 1ns/1ps
module par_mode_dec (
  input  logic [3:0] chan_cnt_i,
  output logic [1:0] ins_cnt_o,
  output logic       hash_o,
  output logic       six_o,
  output logic       bad_o
);
  always_comb begin
    ins_cnt_o = 2'd0;
    hash_o    = 1'b0;
    six_o     = 1'b0;
    bad_o     = 1'b0;
    unique case (chan_cnt_i)
      4'd1: ;
      4'd2: ins_cnt_o = 2'd1;
      4'd3: hash_o = 1'b1;
      4'd4: ins_cnt_o = 2'd2;
      4'd6: begin ins_cnt_o = 2'd1; hash_o = 1'b1; six_o = 1'b1; end
      4'd8: ins_cnt_o = 2'd3;
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/par_grp_insert.sv
`timescale 1ns/1ps
module par_grp_insert #(
  parameter int PA_W  = 40,
  parameter int RA_W  = 64,
  parameter int LOW_W = 7,
  parameter int GID_W = 3
) (
  input  logic [PA_W-1:0]  pa_i,
  input  logic [GID_W-1:0] gid_i,
  input  logic [1:0]       ins_cnt_i,
  output logic [RA_W-1:0]  ia_o
);
  localparam int N_VAR = 4;

  logic [RA_W-1:0] cand [N_VAR];

  for (genvar g = 0; g < N_VAR; g++) begin : g_var
    localparam logic [GID_W-1:0] GMASK = GID_W'((1 << g) - 1);
    assign cand[g] = (RA_W'(pa_i[PA_W-1:LOW_W]) << (LOW_W + g))
                   | (RA_W'(gid_i & GMASK) << LOW_W)
                   | RA_W'(pa_i[LOW_W-1:0]);
  end

  assign ia_o = cand[ins_cnt_i];
endmodule

// File: rtl/par_mod3_solver.sv
`timescale 1ns/1ps
module par_mod3_solver
  import port_real_addr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_bits_i,
  input  logic [1:0] a0_i,
  input  logic [1:0] a1_i,
  input  logic [1:0] a2_i,
  input  logic [2:0] gid_i,
  input  logic       six_i,
  output logic [1:0] k_o,
  output logic       hit_o
);
  res3_t      r0, r1, r2, r3;
  logic [1:0] sel;
  logic [2:0] gid_h;
  logic [2:0] hit_vec;

  assign r0    = b3_code({1'b0, a0_i});
  assign r1    = rot_r(r0, a1_i);
  assign r2    = rot_r(r1, a2_i);
  // Inserted group bit must stay out of the hash in 6-channel mode
  assign sel   = six_i ? {sel_bits_i[1], 1'b0} : sel_bits_i;
  assign gid_h = six_i ? (gid_i & 3'b110) : gid_i;
  assign r3    = rot_l(b3_code(gid_h), sel);

  for (genvar k = 0; k < 3; k++) begin : g_cand
    assign hit_vec[k] = (rot_l(r3, 2'(k)) == r2);
  end

  always_comb begin
    if (hit_vec[1])      k_o = 2'd1;
    else if (hit_vec[2]) k_o = 2'd2;
    else                 k_o = 2'd0;
  end
  assign hit_o = |hit_vec;

  // R6
  hit_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/par_msb_place.sv
`timescale 1ns/1ps
module par_msb_place #(
  parameter int RA_W     = 64,
  parameter int GSZ_W    = 11,
  parameter int MSB_BASE = 30
) (
  input  logic [1:0]       k_i,
  input  logic [GSZ_W-1:0] mask_i,
  output logic [RA_W-1:0]  msb_o
);
  function automatic int pop(input logic [GSZ_W-1:0] v);
    int c = 0;
    for (int i = 0; i < GSZ_W; i++) c += int'(v[i]);
    return c;
  endfunction

  assign msb_o = RA_W'(k_i) << (MSB_BASE + pop(mask_i));
endmodule

// File: rtl/port_real_addr.sv
`timescale 1ns/1ps
module port_real_addr
  import port_real_addr_pkg::*;
#(
  parameter int PA_W     = 40,
  parameter int RA_W     = 64,
  parameter int LOW_W    = 7,
  parameter int GID_W    = 3,
  parameter int GSZ_W    = 11,
  parameter int MSB_BASE = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [PA_W-1:0]  port_addr_i,
  input  logic [3:0]       chan_cnt_i,
  input  logic [GID_W-1:0] grp_id_i,
  input  logic [GSZ_W-1:0] grp_mask_i,
  output logic             out_valid_o,
  output logic [RA_W-1:0]  real_addr_o,
  output logic             err_o
);
  localparam int TOP_USED = PA_W + 3;

  logic [1:0]      ins_cnt;
  logic            hash, six, bad;
  logic [RA_W-1:0] ia, msb, res;
  logic [1:0]      k;
  logic            hit, err_c;

  par_mode_dec u_dec (
    .chan_cnt_i(chan_cnt_i), .ins_cnt_o(ins_cnt),
    .hash_o(hash), .six_o(six), .bad_o(bad)
  );

  par_grp_insert #(.PA_W(PA_W), .RA_W(RA_W), .LOW_W(LOW_W), .GID_W(GID_W)) u_ins (
    .pa_i(port_addr_i), .gid_i(grp_id_i), .ins_cnt_i(ins_cnt), .ia_o(ia)
  );

  par_mod3_solver u_solve (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sel_bits_i(ia[HB_SEL_LO +: 2]),
    .a0_i(ia[HB_A0_LO +: 2]), .a1_i(ia[HB_A1_LO +: 2]), .a2_i(ia[HB_A2_LO +: 2]),
    .gid_i(3'(grp_id_i)), .six_i(six), .k_o(k), .hit_o(hit)
  );

  par_msb_place #(.RA_W(RA_W), .GSZ_W(GSZ_W), .MSB_BASE(MSB_BASE)) u_msb (
    .k_i(k), .mask_i(grp_mask_i), .msb_o(msb)
  );

  assign res   = hash ? (ia | msb) : ia;
  assign err_c = bad | (hash & ~hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      real_addr_o <= '0;
      err_o       <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      err_o       <= in_valid_i & err_c;
      if (in_valid_i) real_addr_o <= res;
    end
  end

  // R9
  lat_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  // R9
  lat_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o && $stable(real_addr_o));
  // R10
  err_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> out_valid_o);
  // R1
  low_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> real_addr_o[LOW_W-1:0] == $past(port_addr_i[LOW_W-1:0]));
  // R2
  pass_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && chan_cnt_i == 4'd1 |=> real_addr_o == RA_W'($past(port_addr_i)) && !err_o);
  // R8
  bad_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !(chan_cnt_i inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8})
    |=> err_o && real_addr_o == RA_W'($past(port_addr_i)));
  // R3
  top_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> real_addr_o[RA_W-1:TOP_USED] == '0);
endmodule

// File: tb/tb_port_real_addr.sv
`timescale 1ns/1ps
module tb_port_real_addr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [39:0] pa = '0;
  logic [3:0]  cnt = 4'd1;
  logic [2:0]  gid = '0;
  logic [10:0] gmask = '0;
  logic        out_valid;
  logic [63:0] ra;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic        v;
    logic [63:0] a;
    logic        e;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  port_real_addr dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .port_addr_i(pa),
    .chan_cnt_i(cnt), .grp_id_i(gid), .grp_mask_i(gmask),
    .out_valid_o(out_valid), .real_addr_o(ra), .err_o(err)
  );

  function automatic logic [63:0] ref_addr(input logic [39:0] p, input int c,
      input logic [2:0] g, input logic [10:0] m, output bit e);
    logic [63:0] ia;
    int n, a0, a1, a2, s, gg, r2, r3, k, pc;
    e = 1'b0;
    n = 0;
    case (c)
      1, 3: n = 0;
      2, 6: n = 1;
      4: n = 2;
      8: n = 3;
      default: e = 1'b1;
    endcase
    ia = ({24'd0, p} >> 7) << (7 + n);
    ia |= 64'(int'(g) & ((1 << n) - 1)) << 7;
    ia |= 64'(p[6:0]);
    if (c == 3 || c == 6) begin
      a0 = int'(ia[16:15]); a1 = int'(ia[18:17]); a2 = int'(ia[20:19]);
      r2 = (a0 % 3 + a1 + a2) % 3;
      s  = (c == 6) ? 2 * int'(ia[8]) : int'(ia[8:7]);
      gg = (c == 6) ? (int'(g) & 6) : int'(g);
      r3 = ((gg % 3) - (s % 3) + 6) % 3;
      k  = (r3 - r2 + 3) % 3;
      pc = $countones(m);
      ia |= 64'(k) << (30 + pc);
    end
    return ia;
  endfunction

  task automatic send(input bit v, input logic [39:0] p, input int c,
      input logic [2:0] g, input logic [10:0] m, input string tag);
    exp_t x;
    bit e;
    @(negedge clk);
    in_valid = v; pa = p; cnt = 4'(c); gid = g; gmask = m;
    x.v = v;
    x.a = ref_addr(p, c, g, m, e);
    x.e = v & e;
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  // Monitor: one queue entry per clock once driving starts
  initial begin
    logic [63:0] last_a;
    exp_t x;
    string t;
    last_a = '0;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && exp_q.size() > 0) begin
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (out_valid !== x.v) begin
          errors++;
          $display("FAIL %s/R9 out_valid got %0b exp %0b", t, out_valid, x.v);
        end else if (x.v) begin
          if (ra !== x.a || err !== x.e) begin
            errors++;
            $display("FAIL %s addr/err got %h/%0b exp %h/%0b", t, ra, err, x.a, x.e);
          end
          last_a = x.a;
        end else if (ra !== last_a || err !== 1'b0) begin
          errors++;
          $display("FAIL R9/R10 idle hold got %h/%0b exp %h/0", t, ra, err, last_a);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int codes[6];
    codes = '{1, 2, 3, 4, 6, 8};
    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if (out_valid !== 1'b0 || ra !== '0 || err !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset got %0b/%h/%0b exp 0/0/0", out_valid, ra, err);
    end
    rst_n = 1'b1;

    send(1, 40'hAB_CDEF_0123, 1, 3'd5, 11'h000, "R2");
    send(1, 40'hFF_FFFF_FFFF, 1, 3'd7, 11'h7FF, "R2");
    send(1, 40'hFF_FFFF_FFFF, 2, 3'd7, 11'h000, "R3");
    send(1, 40'h12_3456_78FF, 4, 3'd6, 11'h000, "R3");
    send(1, 40'hFF_FFFF_FFFF, 8, 3'd7, 11'h000, "R3");
    send(1, 40'h00_0000_007F, 8, 3'd5, 11'h000, "R1");
    send(0, 40'h0, 1, 3'd0, 11'h0, "R9");
    send(0, 40'h5, 2, 3'd1, 11'h0, "R9");
    send(1, 40'h0, 3, 3'd0, 11'h000, "R4");
    send(1, 40'h0, 3, 3'd1, 11'h000, "R4");
    send(1, 40'h0, 3, 3'd2, 11'h7FF, "R7");
    send(1, 40'h0_0018_0180, 3, 3'd4, 11'h155, "R6");
    send(1, 40'h0, 6, 3'd1, 11'h000, "R5");
    send(1, 40'h0, 6, 3'd3, 11'h00F, "R5");
    send(1, 40'h0_001F_8180, 6, 3'd6, 11'h7FF, "R5");
    send(1, 40'h00_0000_0180, 6, 3'd7, 11'h003, "R6");
    for (int c = 0; c < 16; c++)
      if (!(c inside {1, 2, 3, 4, 6, 8}))
        send(1, 40'hC3_5A5A_A5A5, c, 3'd3, 11'h0F0, "R8");
    send(1, 40'h9, 1, 3'd0, 11'h0, "R10");
    for (int i = 0; i < 400; i++) begin
      logic [39:0] rp;
      rp = {$urandom, $urandom} [39:0];
      send(($urandom % 5) != 0, rp, codes[$urandom % 6], 3'($urandom),
           11'($urandom), "R6");
    end
    for (int i = 0; i < 3; i++) send(0, 40'h0, 1, 3'd0, 11'h0, "R9");
    @(negedge clk);
    in_valid = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule